// File: doc/BRIEF.md
# Power-Saving Mode Sequencer

This block is the finite-state controller that moves the digital core of a radio transceiver between its active mode and three power-saving modes: standby, deep sleep and power down. The host selects a target mode through a 2-bit mode-select register. It then issues a sleep command, and later a wake request. The block drives the enables for the RF/MAC/baseband domain, the main oscillator, the regulator and the retention domain. It also reports whether register and FIFO contents are still valid.

The two shallow modes are left through a host wake request. That request starts a fixed stabilization count. Active mode is entered at the end of the count, and a sticky wake-complete interrupt is raised. Power down keeps nothing, ignores wake requests and is left only through the external active-low reset. That reset also returns the mode-select register to its default value.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After `rst_n` is asserted (it is asynchronous, active low), `pm_state` is 0 (active), all four enables are 1, `sel_rd` is 00, `wake_irq` is 0 and `ctx_valid` is 1.
- R2: `cfg_we` loads `cfg_sel` into the mode-select register (read back on `sel_rd`) only while `pm_state` is active. At any other time the write is ignored.
- R3: A `sleep_cmd` pulse in active mode moves `pm_state` on the next edge according to the held mode select. Codes 00 and 10 give standby (1), 01 gives deep sleep (2) and 11 gives power down (3).
- R4: The enables `{rf_en, osc_en, vreg_en, ret_en}` are 1111 in active (0), 0111 in standby (1), 0001 in deep sleep (2), 0000 in power down (3) and 0111 while waking (4).
- R5: The block never moves directly between two power-saving modes. `sleep_cmd` outside active mode has no effect.
- R6: A `wake_cmd` pulse in standby or deep sleep enters waking (4) on the next edge. Active mode is reached exactly `STAB_CYCLES` edges after that.
- R7: `wake_irq` rises on the edge that completes a wake-up. It stays set until `irq_clr` is high on an edge, and completion wins over a simultaneous clear.
- R8: In power down, `wake_cmd` is ignored and `ctx_valid` is 0. Only `rst_n` leaves it, after which `sel_rd` is back to 00.
- R9: Deep sleep and standby keep the mode-select register, so `sel_rd` is unchanged after a wake-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | External active-low reset, asynchronous |
| cfg_we | input | 1 | Mode-select write strobe |
| cfg_sel | input | 2 | Mode-select write data |
| sleep_cmd | input | 1 | Enter power saving (one-cycle pulse) |
| wake_cmd | input | 1 | Wake request (one-cycle pulse) |
| irq_clr | input | 1 | Clear the wake-complete interrupt |
| pm_state | output | 3 | 0 active, 1 standby, 2 deep sleep, 3 power down, 4 waking |
| sel_rd | output | 2 | Mode-select register read-back |
| rf_en | output | 1 | RF/MAC/baseband domain enable |
| osc_en | output | 1 | Main oscillator enable |
| vreg_en | output | 1 | Regulator enable |
| ret_en | output | 1 | Retention/digital-core domain enable |
| ctx_valid | output | 1 | Register and FIFO contents are valid |
| wake_irq | output | 1 | Sticky wake-complete interrupt |

## Verification
The enables and `ctx_valid` are decoded directly from the state register. A wrong state therefore shows on the enable pattern and on `pm_state` one edge after the command that caused it. A stabilization counter that is off by one moves the return to active and the interrupt edge by a cycle, so the bench samples both on either side of the expected edge. A mode-select register that takes writes in the wrong state, or loses its value in a shallow mode, shows on `sel_rd` and on the mode chosen by the next sleep command.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int STAB_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_sel,
  input  logic       sleep_cmd,
  input  logic       wake_cmd,
  input  logic       irq_clr,
  output logic [2:0] pm_state,
  output logic [1:0] sel_rd,
  output logic       rf_en,
  output logic       osc_en,
  output logic       vreg_en,
  output logic       ret_en,
  output logic       ctx_valid,
  output logic       wake_irq
);
  localparam int CW = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

  localparam logic [2:0] S_ACT  = 3'd0;
  localparam logic [2:0] S_STBY = 3'd1;
  localparam logic [2:0] S_DEEP = 3'd2;
  localparam logic [2:0] S_PDN  = 3'd3;
  localparam logic [2:0] S_WAKE = 3'd4;

  logic [2:0]    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    sel_q;
  logic          irq_q;
  logic          wake_done;

  assign wake_done = (st_q == S_WAKE) && (cnt_q == LAST);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      S_ACT: if (sleep_cmd) begin
        if (sel_q == 2'b01)      st_d = S_DEEP;
        else if (sel_q == 2'b11) st_d = S_PDN;
        else                     st_d = S_STBY;
      end
      S_STBY, S_DEEP: if (wake_cmd) begin
        st_d  = S_WAKE;
        cnt_d = '0;
      end
      S_WAKE: if (wake_done) st_d = S_ACT;
              else           cnt_d = cnt_q + 1'b1;
      S_PDN: st_d = S_PDN;
      default: st_d = S_ACT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_ACT;
      cnt_q <= '0;
      sel_q <= 2'b00;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (cfg_we && st_q == S_ACT) sel_q <= cfg_sel;
      if (wake_done)    irq_q <= 1'b1;
      else if (irq_clr) irq_q <= 1'b0;
    end
  end

  assign pm_state  = st_q;
  assign sel_rd    = sel_q;
  assign wake_irq  = irq_q;
  assign rf_en     = (st_q == S_ACT);
  assign osc_en    = (st_q == S_ACT) || (st_q == S_STBY) || (st_q == S_WAKE);
  assign vreg_en   = osc_en;
  assign ret_en    = (st_q != S_PDN);
  assign ctx_valid = (st_q != S_PDN);
endmodule

module pwr_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_we,
  input logic       sleep_cmd,
  input logic       wake_cmd,
  input logic [2:0] pm_state,
  input logic [1:0] sel_rd,
  input logic       rf_en,
  input logic       ctx_valid,
  input logic       wake_irq
);
  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state != 3'd0) |=> $stable(sel_rd));
  // R4
  rf_only_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_en |-> (pm_state == 3'd0));
  // R5
  stby_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd1) |=> (pm_state == 3'd1 || pm_state == 3'd4));
  // R5
  deep_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd2) |=> (pm_state == 3'd2 || pm_state == 3'd4));
  // R8
  pdn_stuck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pm_state == 3'd3) |=> (pm_state == 3'd3));
  // R8
  ctx_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctx_valid |-> (pm_state == 3'd3));
  // R7
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> (pm_state == 3'd0 && $past(pm_state) == 3'd4));
  // R6
  wake_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pm_state == 3'd1 || pm_state == 3'd2) && wake_cmd) |=> (pm_state == 3'd4));
endmodule

bind pwr_seq_ctrl pwr_seq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .sleep_cmd(sleep_cmd),
  .wake_cmd(wake_cmd), .pm_state(pm_state), .sel_rd(sel_rd),
  .rf_en(rf_en), .ctx_valid(ctx_valid), .wake_irq(wake_irq)
);

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STAB = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0, sleep_cmd = 1'b0, wake_cmd = 1'b0, irq_clr = 1'b0;
  logic [1:0] cfg_sel = 2'b00;
  logic [2:0] pm_state;
  logic [1:0] sel_rd;
  logic rf_en, osc_en, vreg_en, ret_en, ctx_valid, wake_irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_seq_ctrl #(.STAB_CYCLES(STAB)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .sleep_cmd(sleep_cmd), .wake_cmd(wake_cmd), .irq_clr(irq_clr),
    .pm_state(pm_state), .sel_rd(sel_rd), .rf_en(rf_en), .osc_en(osc_en),
    .vreg_en(vreg_en), .ret_en(ret_en), .ctx_valid(ctx_valid), .wake_irq(wake_irq)
  );

  // vector: {op[1:0], data[1:0], exp_state[2:0], exp_en[3:0]}
  // op 0 = mode write, 1 = sleep, 2 = wake (waits full stabilization)
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {2'd0, 2'b01, 3'd0, 4'b1111},
    {2'd1, 2'b00, 3'd2, 4'b0001},
    {2'd0, 2'b11, 3'd2, 4'b0001},
    {2'd1, 2'b00, 3'd2, 4'b0001},
    {2'd2, 2'b00, 3'd0, 4'b1111},
    {2'd0, 2'b00, 3'd0, 4'b1111},
    {2'd1, 2'b00, 3'd1, 4'b0111},
    {2'd2, 2'b00, 3'd0, 4'b1111},
    {2'd0, 2'b10, 3'd0, 4'b1111},
    {2'd1, 2'b00, 3'd1, 4'b0111},
    {2'd2, 2'b00, 3'd0, 4'b1111},
    {2'd0, 2'b11, 3'd0, 4'b1111},
    {2'd1, 2'b00, 3'd3, 4'b0000},
    {2'd2, 2'b00, 3'd3, 4'b0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int op, input logic [1:0] d);
    @(negedge clk);
    case (op)
      0: begin cfg_we = 1'b1; cfg_sel = d; end
      1: sleep_cmd = 1'b1;
      default: wake_cmd = 1'b1;
    endcase
    @(negedge clk);
    cfg_we = 1'b0; sleep_cmd = 1'b0; wake_cmd = 1'b0;
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 state", 32'(pm_state), 0);
    chk("R1 enables", {rf_en, osc_en, vreg_en, ret_en}, 4'b1111);
    chk("R1 sel/irq/ctx", {sel_rd, wake_irq, ctx_valid}, {2'b00, 1'b0, 1'b1});
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R5 R6 R8 R9 vector walk
    for (int i = 0; i < NV; i++) begin
      pulse(int'(VEC[i][10:9]), VEC[i][8:7]);
      if (VEC[i][10:9] == 2'd2) repeat (STAB) @(negedge clk);
      chk($sformatf("R3/R4/R5 vec%0d state", i), 32'(pm_state), 32'(VEC[i][6:4]));
      chk($sformatf("R4 vec%0d enables", i), {rf_en, osc_en, vreg_en, ret_en}, VEC[i][3:0]);
      if (i == 2)  chk("R2 write ignored in deep sleep", 32'(sel_rd), 32'(2'b01));
      if (i == 4)  chk("R9 sel kept across deep sleep", 32'(sel_rd), 32'(2'b01));
      if (i == 10) chk("R9 sel kept across standby", 32'(sel_rd), 32'(2'b10));
      if (i == 13) chk("R8 ctx lost in power down", 32'(ctx_valid), 0);
    end

    // R8 reset is the only exit from power down
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset exits power down", 32'(pm_state), 0);
    chk("R8 sel back to default", 32'(sel_rd), 0);
    chk("R8 ctx valid again", 32'(ctx_valid), 1);

    // R6 R7 exact wake timing from standby
    pulse(1, 2'b00);
    chk("R3 standby entered", 32'(pm_state), 1);
    pulse(2, 2'b00);
    chk("R6 waking state", 32'(pm_state), 4);
    chk("R4 waking enables", {rf_en, osc_en, vreg_en, ret_en}, 4'b0111);
    repeat (STAB - 1) @(negedge clk);
    chk("R6 still waking one edge before end", 32'(pm_state), 4);
    chk("R7 irq low before completion", 32'(wake_irq), 0);
    @(negedge clk);
    chk("R6 active after STAB edges", 32'(pm_state), 0);
    chk("R7 irq set on completion", 32'(wake_irq), 1);
    repeat (3) @(negedge clk);
    chk("R7 irq sticky", 32'(wake_irq), 1);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    chk("R7 irq cleared", 32'(wake_irq), 0);

    // R7 completion wins over a simultaneous clear
    pulse(1, 2'b00);
    irq_clr = 1'b1;
    pulse(2, 2'b00);
    repeat (STAB) @(negedge clk);
    chk("R7 set wins over clear", 32'(wake_irq), 1);
    @(negedge clk);
    irq_clr = 1'b0;
    chk("R7 clear after completion", 32'(wake_irq), 0);

    // R5 wake in active mode has no effect
    pulse(2, 2'b00);
    chk("R5 wake ignored in active", 32'(pm_state), 0);
    chk("R5 irq untouched", 32'(wake_irq), 0);

    done = 1'b1;
    summary();
  end
endmodule